// File: doc/BRIEF.md
# Load/Store Byte-Lane Aligner

This block sits between a 32-bit core and a 32-bit data bus and arranges the data lanes for byte, halfword and word accesses. On the load side it takes the raw word fetched from the bus, the low address bits, the access size and a signed flag. It returns the register value, narrowed and extended to the access size and then rotated, or arithmetically shifted for signed loads, by the misalignment. A misaligned access is never faulted.

On the store side it takes a register value and an access size and produces a bus word in which narrow data is copied across every lane. Slaves can then pick their lane from the address without byte enables. Both paths end in a register stage, so each result appears one clock after it is accepted. That delay stands in for the internal idle cycle that follows a load. Every access also raises a nonsequential marker for the bus side.

Top module: `lsu_lane_align`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `ld_valid_o`, `st_valid_o` and `nonseq_o` are 0 and `ld_data_o` and `st_data_o` are all zeros.
- R2: A load accepted on a rising edge with `ld_valid_i` high produces its result on `ld_data_o` with `ld_valid_o` high for exactly the following clock period. In cycles with no accepted load, `ld_valid_o` is 0 and `ld_data_o` keeps its last value.
- R3: A byte load (`ld_is_byte_i`=1) keeps bits [7:0] of the bus word. It fills bits [31:8] with bit 7 when `ld_signed_i`=1 and with zeros otherwise. No shift or rotation is applied, whatever the address.
- R4: A halfword load (`ld_is_half_i`=1, `ld_is_byte_i`=0) keeps bits [15:0], extended by bit 15 when signed and by zeros otherwise. It is then shifted by 8 × `ld_addr_i[0]` bits; `ld_addr_i[1]` has no effect.
- R5: An unsigned word load (both size flags 0) returns the bus word rotated right by 8 × `ld_addr_i[1:0]` bits, with no extension.
- R6: A signed word or halfword load uses an arithmetic right shift by the same amount instead of a rotation, so the vacated upper bytes copy the sign bit of the extended value.
- R7: When `ld_is_byte_i` and `ld_is_half_i` are both 1, a load is treated as a byte load; likewise `st_is_byte_i` overrides `st_is_half_i` for a store.
- R8: A byte store drives bits [7:0] of `st_data_i` into all four byte lanes of `st_data_o`.
- R9: A halfword store drives bits [15:0] of `st_data_i` into both bits [15:0] and bits [31:16] of `st_data_o`.
- R10: A word store passes `st_data_i` unchanged. Store results appear with `st_valid_o` high in the clock period after `st_valid_i` is accepted; otherwise `st_valid_o` is 0 and `st_data_o` holds.
- R11: `nonseq_o` is 1 in exactly the clock periods that follow an accepted load or store, including the case where both are accepted together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid_i | input | 1 | Bus read data is present this cycle |
| ld_data_i | input | 32 | Raw word fetched from the bus |
| ld_addr_i | input | 2 | Low bits of the load address |
| ld_is_half_i | input | 1 | Load is a halfword |
| ld_is_byte_i | input | 1 | Load is a byte (overrides halfword) |
| ld_signed_i | input | 1 | Sign-extend and shift arithmetically |
| ld_valid_o | output | 1 | Load result valid pulse |
| ld_data_o | output | 32 | Aligned, extended load result |
| st_valid_i | input | 1 | Store value presented this cycle |
| st_data_i | input | 32 | Register value to store |
| st_is_half_i | input | 1 | Store is a halfword |
| st_is_byte_i | input | 1 | Store is a byte (overrides halfword) |
| st_valid_o | output | 1 | Store bus word valid |
| st_data_o | output | 32 | Lane-replicated bus word |
| nonseq_o | output | 1 | Marks the access as nonsequential |

## Verification
On every cycle, the assertions check the one-cycle timing of both valid pulses and of `nonseq_o`, and that load data holds between loads. They also check that unsigned byte loads leave the upper bits clear, that an aligned unsigned word load passes through unchanged, and that narrow stores fill every lane or half with the same value. The exact load value depends on the combination of size, sign and misalignment, including the byte-over-halfword priority and the unused address bit 1 on halfword loads. Only the bench's reference model shows these values, by comparing every output on every clock against independently computed results over directed and random accesses.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

   typedef enum logic [1:0] {
      SZ_WORD = 2'd0,
      SZ_HALF = 2'd1,
      SZ_BYTE = 2'd2
   } acc_size_e;

   // byte flag takes priority over halfword flag (R7)
   function automatic acc_size_e size_from_flags(input logic is_half, input logic is_byte);
      if (is_byte)      return SZ_BYTE;
      else if (is_half) return SZ_HALF;
      else              return SZ_WORD;
   endfunction

endpackage

// File: rtl/lsu_load_extend.sv
module lsu_load_extend
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_size_e           size_i,
   input  logic                sgn_i,
   input  logic [DATA_W-1:0]   raw_i,
   output logic [DATA_W-1:0]   ext_o
);
   localparam int HALF_W = 16;
   localparam int BYTE_W = 8;

   logic half_fill;
   logic byte_fill;

   assign half_fill = sgn_i & raw_i[HALF_W-1];
   assign byte_fill = sgn_i & raw_i[BYTE_W-1];

   always_comb begin
      case (size_i)
         SZ_BYTE: ext_o = {{(DATA_W-BYTE_W){byte_fill}}, raw_i[BYTE_W-1:0]};
         SZ_HALF: ext_o = {{(DATA_W-HALF_W){half_fill}}, raw_i[HALF_W-1:0]};
         default: ext_o = raw_i;
      endcase
   end

endmodule

// File: rtl/lsu_load_shift.sv
module lsu_load_shift #(
   parameter int DATA_W = 32,
   parameter int LO_W   = $clog2(DATA_W/8)
) (
   input  logic [DATA_W-1:0] val_i,
   input  logic [LO_W-1:0]   bytes_i,
   input  logic              arith_i,
   output logic [DATA_W-1:0] val_o
);
   logic [DATA_W-1:0] stg [0:LO_W];

   assign stg[0] = val_i;

   // one stage per address bit, each moving 8 << k bits
   for (genvar k = 0; k < LO_W; k++) begin : g_stage
      localparam int SH = 8 << k;
      logic [DATA_W-1:0] rot_v;
      logic [DATA_W-1:0] asr_v;
      assign rot_v = {stg[k][SH-1:0], stg[k][DATA_W-1:SH]};
      assign asr_v = {{SH{stg[k][DATA_W-1]}}, stg[k][DATA_W-1:SH]};
      assign stg[k+1] = bytes_i[k] ? (arith_i ? asr_v : rot_v) : stg[k];
   end

   assign val_o = stg[LO_W];

endmodule

// File: rtl/lsu_store_replicate.sv
module lsu_store_replicate
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_size_e         size_i,
   input  logic [DATA_W-1:0] val_i,
   output logic [DATA_W-1:0] bus_o
);
   localparam int LANES = DATA_W / 8;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      localparam int HALF_SRC = 8 * (i % 2);
      assign bus_o[8*i +: 8] = (size_i == SZ_BYTE) ? val_i[7:0] :
                               (size_i == SZ_HALF) ? val_i[HALF_SRC +: 8] :
                                                     val_i[8*i +: 8];
   end

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
   import lsu_align_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LO_W   = $clog2(DATA_W/8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_valid_i,
   input  logic [DATA_W-1:0] ld_data_i,
   input  logic [LO_W-1:0]   ld_addr_i,
   input  logic              ld_is_half_i,
   input  logic              ld_is_byte_i,
   input  logic              ld_signed_i,
   output logic              ld_valid_o,
   output logic [DATA_W-1:0] ld_data_o,
   input  logic              st_valid_i,
   input  logic [DATA_W-1:0] st_data_i,
   input  logic              st_is_half_i,
   input  logic              st_is_byte_i,
   output logic              st_valid_o,
   output logic [DATA_W-1:0] st_data_o,
   output logic              nonseq_o
);
   // elaboration-time parameter checks
   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("lsu_lane_align: DATA_W must be a power of two of at least 32");
   end
   if (LO_W != $clog2(DATA_W/8)) begin : g_bad_lo
      $error("lsu_lane_align: LO_W must equal log2 of the byte count");
   end

   acc_size_e         ld_size;
   acc_size_e         st_size;
   logic [LO_W-1:0]   ld_amt;
   logic [DATA_W-1:0] ld_ext;
   logic [DATA_W-1:0] ld_aligned;
   logic [DATA_W-1:0] st_bus;

   assign ld_size = size_from_flags(ld_is_half_i, ld_is_byte_i);
   assign st_size = size_from_flags(st_is_half_i, st_is_byte_i);

   // effective byte offset: bytes none, halfwords bit 0 only, words all bits
   always_comb begin
      case (ld_size)
         SZ_BYTE: ld_amt = '0;
         SZ_HALF: ld_amt = LO_W'(ld_addr_i[0]);
         default: ld_amt = ld_addr_i;
      endcase
   end

   lsu_load_extend #(.DATA_W(DATA_W)) u_ext (
      .size_i (ld_size),
      .sgn_i  (ld_signed_i),
      .raw_i  (ld_data_i),
      .ext_o  (ld_ext)
   );

   lsu_load_shift #(.DATA_W(DATA_W), .LO_W(LO_W)) u_shift (
      .val_i   (ld_ext),
      .bytes_i (ld_amt),
      .arith_i (ld_signed_i),
      .val_o   (ld_aligned)
   );

   lsu_store_replicate #(.DATA_W(DATA_W)) u_rep (
      .size_i (st_size),
      .val_i  (st_data_i),
      .bus_o  (st_bus)
   );

   // output stage: one clock models the post-load idle cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_valid_o <= 1'b0;
         ld_data_o  <= '0;
         st_valid_o <= 1'b0;
         st_data_o  <= '0;
         nonseq_o   <= 1'b0;
      end else begin
         ld_valid_o <= ld_valid_i;
         st_valid_o <= st_valid_i;
         nonseq_o   <= ld_valid_i | st_valid_i;
         if (ld_valid_i) ld_data_o <= ld_aligned;
         if (st_valid_i) st_data_o <= st_bus;
      end
   end

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
   parameter int DATA_W = 32,
   parameter int LO_W   = $clog2(DATA_W/8)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid_i,
   input logic [DATA_W-1:0] ld_data_i,
   input logic [LO_W-1:0]   ld_addr_i,
   input logic              ld_is_half_i,
   input logic              ld_is_byte_i,
   input logic              ld_signed_i,
   input logic              ld_valid_o,
   input logic [DATA_W-1:0] ld_data_o,
   input logic              st_valid_i,
   input logic [DATA_W-1:0] st_data_i,
   input logic              st_is_half_i,
   input logic              st_is_byte_i,
   input logic              st_valid_o,
   input logic [DATA_W-1:0] st_data_o,
   input logic              nonseq_o
);
   localparam int LANES = DATA_W / 8;

   // R2
   ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid_i |=> ld_valid_o);

   // R2
   ld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid_i |=> (!ld_valid_o && $stable(ld_data_o)));

   // R3
   byte_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i && ld_is_byte_i && !ld_signed_i) |=> (ld_data_o[DATA_W-1:8] == '0));

   // R5
   word_aligned_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i && !ld_is_byte_i && !ld_is_half_i && !ld_signed_i && ld_addr_i == '0)
      |=> (ld_data_o == $past(ld_data_i)));

   // R8
   byte_store_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid_i && st_is_byte_i) |=> (st_data_o == {LANES{$past(st_data_i[7:0])}}));

   // R9
   half_store_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid_i && st_is_half_i && !st_is_byte_i)
      |=> (st_data_o == {(LANES/2){$past(st_data_i[15:0])}}));

   // R10
   st_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid_i |=> st_valid_o);

   // R10
   st_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid_i |=> (!st_valid_o && $stable(st_data_o)));

   // R11
   nonseq_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid_i || st_valid_i) |=> nonseq_o);

   // R11
   nonseq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_valid_i && !st_valid_i) |=> !nonseq_o);

endmodule

bind lsu_lane_align lsu_lane_align_chk #(.DATA_W(DATA_W), .LO_W(LO_W)) u_chk (.*);

// File: tb/lsu_lane_align_bench.sv
module lsu_lane_align_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_valid_i = 1'b0;
   logic [31:0] ld_data_i = '0;
   logic [1:0]  ld_addr_i = '0;
   logic        ld_is_half_i = 1'b0;
   logic        ld_is_byte_i = 1'b0;
   logic        ld_signed_i = 1'b0;
   logic        ld_valid_o;
   logic [31:0] ld_data_o;
   logic        st_valid_i = 1'b0;
   logic [31:0] st_data_i = '0;
   logic        st_is_half_i = 1'b0;
   logic        st_is_byte_i = 1'b0;
   logic        st_valid_o;
   logic [31:0] st_data_o;
   logic        nonseq_o;

   int errors = 0;
   int checks = 0;
   bit running = 0;
   bit done = 0;

   always #2 clk = ~clk;

   lsu_lane_align u_lsu_lane_align (.*);

   // behavioural reference state
   logic        exp_ld_v = 0, exp_st_v = 0, exp_ns = 0;
   logic [31:0] exp_ld_d = '0, exp_st_d = '0;
   string       ld_tag = "R1", st_tag = "R1";

   function automatic logic [31:0] ref_load(input logic [31:0] w, input logic [1:0] a,
                                            input logic h, input logic b, input logic s);
      longint v;
      int     sh;
      logic [63:0] dbl;
      if (b) begin
         v  = s ? longint'($signed(w[7:0])) : longint'(w[7:0]);
         sh = 0;
      end else if (h) begin
         v  = s ? longint'($signed(w[15:0])) : longint'(w[15:0]);
         sh = 8 * int'(a[0]);
      end else begin
         v  = s ? longint'($signed(w)) : longint'(w);
         sh = 8 * int'(a);
      end
      if (s) return 32'(v >>> sh);
      dbl = {v[31:0], v[31:0]} >> sh;
      return dbl[31:0];
   endfunction

   function automatic logic [31:0] ref_store(input logic [31:0] d, input logic h, input logic b);
      if (b) return {4{d[7:0]}};
      if (h) return {2{d[15:0]}};
      return d;
   endfunction

   function automatic string load_tag(input logic h, input logic b, input logic s);
      if (b && h) return "R7";
      if (b)      return "R3";
      if (s)      return "R6";
      if (h)      return "R4";
      return "R5";
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         exp_ld_v <= 0; exp_st_v <= 0; exp_ns <= 0;
         exp_ld_d <= '0; exp_st_d <= '0;
      end else begin
         exp_ld_v <= ld_valid_i;
         exp_st_v <= st_valid_i;
         exp_ns   <= ld_valid_i | st_valid_i;
         if (ld_valid_i) begin
            exp_ld_d <= ref_load(ld_data_i, ld_addr_i, ld_is_half_i, ld_is_byte_i, ld_signed_i);
            ld_tag   <= load_tag(ld_is_half_i, ld_is_byte_i, ld_signed_i);
         end
         if (st_valid_i) begin
            exp_st_d <= ref_store(st_data_i, st_is_half_i, st_is_byte_i);
            st_tag   <= st_is_byte_i ? (st_is_half_i ? "R7" : "R8") : (st_is_half_i ? "R9" : "R10");
         end
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%08h expected=%08h at %0t", req, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (running) begin
         check("R2",  32'(ld_valid_o), 32'(exp_ld_v));
         check(ld_tag, ld_data_o, exp_ld_d);
         check("R10", 32'(st_valid_o), 32'(exp_st_v));
         check(st_tag, st_data_o, exp_st_d);
         check("R11", 32'(nonseq_o), 32'(exp_ns));
      end
   end

   task automatic put_load(input logic [31:0] w, input logic [1:0] a,
                           input logic h, input logic b, input logic s);
      ld_valid_i = 1; ld_data_i = w; ld_addr_i = a;
      ld_is_half_i = h; ld_is_byte_i = b; ld_signed_i = s;
   endtask

   task automatic put_store(input logic [31:0] d, input logic h, input logic b);
      st_valid_i = 1; st_data_i = d; st_is_half_i = h; st_is_byte_i = b;
   endtask

   task automatic idle_inputs();
      ld_valid_i = 0; st_valid_i = 0;
      ld_data_i = 32'hDEAD_BEEF; st_data_i = 32'hFACE_CAFE;
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1", 32'(ld_valid_o), 0);
      check("R1", ld_data_o, 0);
      check("R1", 32'(st_valid_o), 0);
      check("R1", st_data_o, 0);
      check("R1", 32'(nonseq_o), 0);
      rst_n = 1;
      running = 1;
      step();
      // R3 signed byte at address 3: no shift
      put_load(32'h1234_56F0, 2'd3, 0, 1, 1); step();
      // R4 unsigned half at address 3: addr[1] ignored
      put_load(32'h1234_ABCD, 2'd3, 1, 0, 0); step();
      // R6 signed half at address 1
      put_load(32'h0000_8001, 2'd1, 1, 0, 1); step();
      // R5 unsigned word rotations
      for (int a = 0; a < 4; a++) begin
         put_load(32'h8844_2211, 2'(a), 0, 0, 0); step();
      end
      // R6 signed word arithmetic shifts
      for (int a = 0; a < 4; a++) begin
         put_load(32'h8844_2211, 2'(a), 0, 0, 1); step();
      end
      // R7 both flags on load and store
      put_load(32'h0000_C3A5, 2'd2, 1, 1, 1);
      put_store(32'h1122_3344, 1, 1); step();
      // R8, R9, R10 stores
      idle_inputs();
      put_store(32'hAABB_CCDD, 0, 1); step();
      put_store(32'hAABB_CCDD, 1, 0); step();
      put_store(32'hAABB_CCDD, 0, 0); step();
      // R2 hold with no traffic
      idle_inputs(); step(); step();
      // R11 simultaneous accesses
      put_load(32'h7F00_0080, 2'd0, 0, 1, 1);
      put_store(32'h0000_00FF, 0, 1); step();
      idle_inputs(); step();
      // random traffic
      for (int n = 0; n < 3000; n++) begin
         ld_valid_i   = ($urandom % 3) != 0;
         ld_data_i    = $urandom;
         ld_addr_i    = 2'($urandom);
         ld_is_half_i = 1'($urandom);
         ld_is_byte_i = 1'($urandom);
         ld_signed_i  = 1'($urandom);
         st_valid_i   = ($urandom % 3) != 0;
         st_data_i    = $urandom;
         st_is_half_i = 1'($urandom);
         st_is_byte_i = 1'($urandom);
         step();
      end
      idle_inputs(); step(); step();
      running = 0;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule